// File: doc/BRIEF.md
# Register Command Stream Decoder

This block sits behind a byte-wide link that carries display-control commands. It scans the stream for a one-byte command marker (0xAF). After the marker comes an opcode. When the opcode is the register-write code (0x20), two more bytes follow: a register index and a value. The block applies these writes to a bank of display configuration registers. It also drives the decoded fields of that bank to the display pipeline: pixel depth, blanking mode, the two frame-buffer base pointers, twelve 16-bit timing fields and the pixel clock.

Writes can be grouped into an atomic update through a dedicated lock index (0xFF).
- While the bank is locked, writes only fill a shadow copy, and the outputs do not move.
- Writing 0xFF to the lock index publishes the whole shadow copy in a single cycle.
- While the bank is unlocked, every write reaches the outputs at once.

Any command whose opcode is not a register write is abandoned. The parser then hunts for the next marker and drops every byte until it sees one.

Top module: `cmd_regfile_top`

## Requirements
- R1: After reset the bank is locked and the blanking byte reads 0x07 (power-down). Depth, both base pointers, every timing field and the pixel clock read zero.
- R2: A write command is the byte sequence 0xAF, 0x20, index, value. The register is updated at the clock edge that accepts the value byte.
- R3: While hunting for a command, any byte other than 0xAF is discarded. The next 0xAF starts a fresh command.
- R4: If the byte after 0xAF is anything other than 0x20, the command is dropped and the parser returns to hunting. The rest of that command's bytes have no effect.
- R5: Writing 0x00 to index 0xFF locks the bank. While locked, writes to mapped indices leave every output unchanged.
- R6: Writing 0xFF to index 0xFF unlocks the bank. In the same cycle it copies every staged value to the outputs.
- R7: While unlocked, a write to a mapped index changes the output on the edge that accepts the value byte. This includes the blanking byte at index 0x1F, where 0x00 means syncs on, 0x01 means blanked and 0x07 means power-down.
- R8: Bit 0 of index 0x00 selects pixel depth: 0 gives 16 bpp and 1 gives 24 bpp.
- R9: Each base pointer is 24 bits wide and is stored most significant byte first. The 16 bpp pointer uses indices 0x20, 0x21 and 0x22. The 8 bpp pointer uses 0x26, 0x27 and 0x28.
- R10: Timing field k (k = 0..11) takes its high byte from index 0x01+2k and its low byte from 0x02+2k. It appears at bits [16k+15:16k] of the timing output.
- R11: The pixel clock, in 5 kHz units, takes its low byte from index 0x1B and its high byte from 0x1C.
- R12: Two kinds of write leave every output unchanged: a value other than 0x00 or 0xFF written to index 0xFF, and a write to an index from 0x30 through 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always high; a byte is taken on every valid cycle |
| locked | output | 1 | Bank is staging writes |
| depth_24 | output | 1 | 24 bpp selected |
| blank_mode | output | 8 | Committed blanking byte |
| base16 | output | 24 | 16 bpp frame-buffer base |
| base8 | output | 24 | 8 bpp frame-buffer base |
| pix_clk | output | 16 | Pixel clock in 5 kHz units |
| timing_fields | output | 192 | Twelve 16-bit timing fields, field 0 in the low bits |
| regs_flat | output | 384 | Whole committed bank, index i at bits [8i+7:8i] |

## Verification
The assertions assume the following about the stream:
- Bytes arrive only when the source means them, and a command's bytes arrive in order with nothing interleaved.
- A value byte equal to 0xAF is treated as data, because the parser has already left its hunting state.

The stimulus holds valid for exactly one edge per byte. Resynchronisation is tested with garbage bytes that contain no 0xAF, so every expected value follows directly from the command sequence the bench sent.

// File: rtl/cmd_regfile_pkg.sv
// Package: constants and parser state shared by the decoder modules.
// Assumes an 8-bit stream; all codes are single bytes.
package cmd_regfile_pkg;
    localparam logic [7:0] CMD_MARK    = 8'hAF;
    localparam logic [7:0] OP_REGWR    = 8'h20;
    localparam logic [7:0] IDX_LOCK    = 8'hFF;
    localparam logic [7:0] LOCK_SET    = 8'h00;
    localparam logic [7:0] LOCK_CLEAR  = 8'hFF;
    localparam int         IDX_DEPTH   = 'h00;
    localparam int         IDX_BLANK   = 'h1F;
    localparam int         IDX_PCLK    = 'h1B;
    localparam int         IDX_BASE16  = 'h20;
    localparam int         IDX_BASE8   = 'h26;
    localparam int         IDX_TIMING  = 'h01;
    localparam logic [7:0] BLANK_POWER_DOWN = 8'h07;

    typedef enum logic [1:0] {
        PS_HUNT  = 2'd0,
        PS_OPC   = 2'd1,
        PS_INDEX = 2'd2,
        PS_VALUE = 2'd3
    } parse_state_t;
endpackage

// File: rtl/cmd_parser.sv
// Module: cmd_parser
// Turns the byte stream into register write strobes.
// Assumes the source holds each byte for a single valid cycle; every byte is accepted.
module cmd_parser
    import cmd_regfile_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val
);
    parse_state_t state_q;
    logic [7:0]   idx_q;

    // Command framing: hunt for the marker, then opcode, index and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_HUNT;
            idx_q   <= 8'h00;
        end else if (in_valid) begin
            case (state_q)
                PS_HUNT:  state_q <= (in_data == CMD_MARK) ? PS_OPC : PS_HUNT;
                PS_OPC:   state_q <= (in_data == OP_REGWR) ? PS_INDEX : PS_HUNT;
                PS_INDEX: begin
                    idx_q   <= in_data;
                    state_q <= PS_VALUE;
                end
                default:  state_q <= PS_HUNT;
            endcase
        end
    end

    // Write strobe: fires on the cycle that carries the value byte.
    always_comb begin
        wr_en  = in_valid && (state_q == PS_VALUE);
        wr_idx = idx_q;
        wr_val = in_data;
    end

    AST_HUNT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HUNT && in_valid && in_data != CMD_MARK) |=> state_q == PS_HUNT); // R3
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPC && in_valid && in_data != OP_REGWR) |=> state_q == PS_HUNT); // R4
    AST_WRITE_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OPC && in_valid && in_data == OP_REGWR) |=> state_q == PS_INDEX); // R2
endmodule

// File: rtl/cmd_reg_bank.sv
// Module: cmd_reg_bank
// Holds a shadow bank and a committed bank of NREG byte registers, plus the lock flag.
// Assumes at most one write per cycle; indices at or above NREG (other than the lock index) are dropped.
module cmd_reg_bank
    import cmd_regfile_pkg::*;
#(
    parameter int NREG = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           wr_idx,
    input  logic [7:0]           wr_val,
    output logic                 locked,
    output logic [NREG-1:0][7:0] active
);
    localparam int         IW     = $clog2(NREG);
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic [NREG-1:0][7:0] shadow_q;
    logic [NREG-1:0][7:0] active_q;
    logic                 locked_q;
    logic                 is_lock_idx;
    logic                 in_map;
    logic [IW-1:0]        slot;

    // Index decode: lock index or a slot of the bank.
    always_comb begin
        is_lock_idx = (wr_idx == IDX_LOCK);
        in_map      = (wr_idx < NREG_B);
        slot        = wr_idx[IW-1:0];
    end

    // Bank update: staging, direct writes and whole-bank commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
            for (int i = 0; i < NREG; i++) begin
                shadow_q[i] <= (i == IDX_BLANK) ? BLANK_POWER_DOWN : 8'h00;
                active_q[i] <= (i == IDX_BLANK) ? BLANK_POWER_DOWN : 8'h00;
            end
        end else if (wr_en) begin
            if (is_lock_idx) begin
                if (wr_val == LOCK_SET) begin
                    locked_q <= 1'b1;
                end else if (wr_val == LOCK_CLEAR) begin
                    locked_q <= 1'b0;
                    active_q <= shadow_q;
                end
            end else if (in_map) begin
                shadow_q[slot] <= wr_val;
                if (!locked_q) begin
                    active_q[slot] <= wr_val;
                end
            end
        end
    end

    assign locked = locked_q;
    assign active = active_q;

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !(wr_en && is_lock_idx && wr_val == LOCK_CLEAR)) |=> $stable(active_q)); // R5
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_lock_idx && wr_val == LOCK_SET) |=> locked_q); // R5
    AST_UNLOCK_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_lock_idx && wr_val == LOCK_CLEAR) |=> (!locked_q && active_q == $past(shadow_q))); // R6
    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q && wr_en && in_map) |=> active_q[$past(slot)] == $past(wr_val)); // R7
    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_map && !is_lock_idx) |=> ($stable(active_q) && $stable(locked_q))); // R12
endmodule

// File: rtl/cmd_regfile_top.sv
// Module: cmd_regfile_top
// Decodes register-write commands from a byte stream and drives the committed display configuration.
// Assumes NREG covers every mapped field (at least 0x29 entries).
module cmd_regfile_top
    import cmd_regfile_pkg::*;
#(
    parameter int NREG   = 48,
    parameter int NFIELD = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 locked,
    output logic                 depth_24,
    output logic [7:0]           blank_mode,
    output logic [23:0]          base16,
    output logic [23:0]          base8,
    output logic [15:0]          pix_clk,
    output logic [NFIELD*16-1:0] timing_fields,
    output logic [NREG*8-1:0]    regs_flat
);
    logic                 wr_en;
    logic [7:0]           wr_idx;
    logic [7:0]           wr_val;
    logic [NREG-1:0][7:0] bank;

    cmd_parser u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val)
    );

    cmd_reg_bank #(.NREG(NREG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .locked (locked),
        .active (bank)
    );

    // Field view: high-byte-first timing fields, one per register pair.
    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        assign timing_fields[k*16 +: 16] = {bank[IDX_TIMING + 2*k], bank[IDX_TIMING + 2*k + 1]};
    end

    // Field view: pointers, clock, depth and blanking byte.
    always_comb begin
        in_ready   = 1'b1;
        depth_24   = bank[IDX_DEPTH][0];
        blank_mode = bank[IDX_BLANK];
        base16     = {bank[IDX_BASE16], bank[IDX_BASE16+1], bank[IDX_BASE16+2]};
        base8      = {bank[IDX_BASE8],  bank[IDX_BASE8+1],  bank[IDX_BASE8+2]};
        pix_clk    = {bank[IDX_PCLK+1], bank[IDX_PCLK]};
        regs_flat  = bank;
    end

    AST_BLANK_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(wr_en && wr_idx == IDX_LOCK)) |=> $stable(blank_mode)); // R5
endmodule

// File: tb/cmd_regfile_top_test.sv
module cmd_regfile_top_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = 8'h00;
    logic         in_ready, locked, depth_24;
    logic [7:0]   blank_mode;
    logic [23:0]  base16, base8;
    logic [15:0]  pix_clk;
    logic [191:0] timing_fields;
    logic [383:0] regs_flat;
    int n_checks = 0;
    int n_fail   = 0;

    cmd_regfile_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .locked(locked), .depth_24(depth_24),
        .blank_mode(blank_mode), .base16(base16), .base8(base8),
        .pix_clk(pix_clk), .timing_fields(timing_fields), .regs_flat(regs_flat)
    );

    always #5ns clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One byte accepted at the next rising edge; returns at the falling edge after it.
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        put(8'hAF); put(8'h20); put(idx); put(val);
    endtask

    task automatic t_reset;
        check("R1 locked", {31'd0, locked}, 32'd1);
        check("R1 blank", {24'd0, blank_mode}, 32'h07);
        check("R1 base16", {8'd0, base16}, 32'd0);
        check("R1 base8", {8'd0, base8}, 32'd0);
        check("R1 depth", {31'd0, depth_24}, 32'd0);
        check("R1 timing", {31'd0, |timing_fields}, 32'd0);
        check("R1 pclk", {16'd0, pix_clk}, 32'd0);
    endtask

    task automatic t_stage;
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56); wr(8'h1F, 8'h00);
        check("R5 base16 held", {8'd0, base16}, 32'd0);
        check("R5 blank held", {24'd0, blank_mode}, 32'h07);
        wr(8'hFF, 8'hFF);
        check("R6 unlocked", {31'd0, locked}, 32'd0);
        check("R6 R9 base16 commit", {8'd0, base16}, 32'h123456);
        check("R6 blank commit", {24'd0, blank_mode}, 32'h00);
    endtask

    task automatic t_direct;
        wr(8'h1F, 8'h01);
        check("R7 blank direct", {24'd0, blank_mode}, 32'h01);
        wr(8'h26, 8'hAB);
        check("R7 base8 partial", {8'd0, base8}, 32'hAB0000);
        wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
        check("R9 base8", {8'd0, base8}, 32'hABCDEF);
        wr(8'h00, 8'h01);
        check("R8 depth 24", {31'd0, depth_24}, 32'd1);
        check("R2 reg 0 value", {24'd0, regs_flat[7:0]}, 32'h01);
    endtask

    task automatic t_fields;
        wr(8'h07, 8'h02); wr(8'h08, 8'h58);
        check("R10 field3", {16'd0, timing_fields[3*16 +: 16]}, 32'h0258);
        wr(8'h17, 8'h03); wr(8'h18, 8'h00);
        check("R10 field11", {16'd0, timing_fields[11*16 +: 16]}, 32'h0300);
        wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
        check("R11 pclk", {16'd0, pix_clk}, 32'h1234);
    endtask

    task automatic t_resync;
        put(8'h00); put(8'h20); put(8'h1F); put(8'h07);
        check("R3 garbage dropped", {24'd0, blank_mode}, 32'h01);
        put(8'h13); put(8'hAF); put(8'h20); put(8'h1F); put(8'h00);
        check("R3 resync write", {24'd0, blank_mode}, 32'h00);
    endtask

    task automatic t_opcode;
        put(8'hAF); put(8'h6A); put(8'h1F); put(8'h07);
        check("R4 other opcode dropped", {24'd0, blank_mode}, 32'h00);
        wr(8'h1F, 8'h01);
        check("R4 recovery", {24'd0, blank_mode}, 32'h01);
    endtask

    task automatic t_ignore;
        wr(8'hFF, 8'h55);
        check("R12 lock value ignored", {31'd0, locked}, 32'd0);
        wr(8'h40, 8'h99);
        check("R12 unmapped base16", {8'd0, base16}, 32'h123456);
        check("R12 unmapped base8", {8'd0, base8}, 32'hABCDEF);
        check("R12 unmapped blank", {24'd0, blank_mode}, 32'h01);
        wr(8'hFF, 8'h00);
        check("R5 relock", {31'd0, locked}, 32'd1);
        wr(8'h1F, 8'h07);
        check("R5 blank staged", {24'd0, blank_mode}, 32'h01);
        wr(8'hFF, 8'hFF);
        check("R6 blank published", {24'd0, blank_mode}, 32'h07);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_direct();
        t_fields();
        t_resync();
        t_opcode();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule